// File: doc/BRIEF.md
# Interrupt Enable and Flag Controller

The block holds one 8-bit interrupt control register and drives one interrupt request. The register has a master enable, an enable for a group of peripheral interrupts, three source enables and three sticky flags. The three sources are a one-cycle timer overflow pulse, an external pin whose active edge can be selected, and a change on a 4-bit port compared against a stored snapshot. Flags latch whenever their condition occurs, whatever the enables are set to. Software reads the register directly and writes it as a whole byte. Writing a 0 to a flag bit clears that flag.

The port-change flag needs a port read before it can be cleared. The port pins are compared against a snapshot, and only the port-read strobe refreshes that snapshot. While the pins differ from the snapshot, the flag is set again on every cycle, so a software clear does not hold. Once a port read has re-captured the pins, a clear takes effect. The external pin and the port pins each pass through a two-flop synchronizer before edge or mismatch detection.

Top module: `intr_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and `irq_o` is 0.
- R2: Register bit positions are fixed: bit 7 master enable, bit 6 peripheral-group enable, bit 5 timer enable, bit 4 external-pin enable, bit 3 port-change enable, bit 2 timer flag, bit 1 external-pin flag, bit 0 port-change flag. A write with no source event in that cycle reads back the written byte on the next cycle.
- R3: A cycle with `tmr_ovf_i` high sets bit 2 on the next clock edge. This happens whatever the enable bits hold.
- R4: With `edge_rise_sel_i` at 1, a low-to-high change on `ext_pin_i` sets bit 1 within four clock edges, and a high-to-low change does not set it. With `edge_rise_sel_i` at 0, only a high-to-low change sets bit 1. The enables have no effect on this.
- R5: A set flag stays set until a write places 0 in its bit.
- R6: When the synchronized port pins differ from the snapshot, bit 0 is set. While that mismatch lasts, a write of 0 to bit 0 leaves it reading 1 on the following cycles.
- R7: A one-cycle `port_rd_i` pulse copies the current synchronized pins into the snapshot. After that, a write of 0 to bit 0 clears the flag.
- R8: If a flag's set event and a write of 0 to that flag fall in the same cycle, the flag reads 1 afterwards.
- R9: `irq_o` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periph_irq_i`)). When bit 7 is 0, `irq_o` is 0.
- R10: `periph_irq_i` raises `irq_o` only while both bit 7 and bit 6 are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_ovf_i | input | 1 | Timer overflow pulse, synchronous to clk |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| port_hi_i | input | 4 | Upper port pins watched for change, asynchronous |
| port_rd_i | input | 1 | Port-read strobe; refreshes the snapshot |
| edge_rise_sel_i | input | 1 | 1: rising edge of ext pin, 0: falling edge |
| periph_irq_i | input | 1 | Combined peripheral-group request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register contents |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a software clear that meets a port mismatch that is still present. A plain write can never clear the flag then. The stimulus has to move the port pins, wait for the synchronizer, issue a clear and see it fail, then pulse the port-read strobe and clear again. That path is driven directly, with the wait counted in cycles. The same-cycle collision of a timer pulse and a clearing write is also forced directly. Random write, pulse and peripheral traffic then runs against a model of the register kept in the bench.

// File: rtl/intr_ctrl_pkg.sv
package intr_ctrl_pkg;
  localparam int REG_W  = 8;
  localparam int B_MEN  = 7;
  localparam int B_GEN  = 6;
  localparam int B_TEN  = 5;
  localparam int B_XEN  = 4;
  localparam int B_CEN  = 3;
  localparam int B_TFL  = 2;
  localparam int B_XFL  = 1;
  localparam int B_CFL  = 0;

  // Next value of a sticky flag: a set event beats a clearing write.
  function automatic logic flag_next(logic cur, logic wr, logic wbit, logic set_evt);
    return set_evt | (wr ? wbit : cur);
  endfunction

  // Request from the register contents and the peripheral-group input.
  function automatic logic irq_eval(logic [REG_W-1:0] r, logic periph);
    logic any_src;
    any_src = (r[B_TEN] & r[B_TFL]) | (r[B_XEN] & r[B_XFL]) |
              (r[B_CEN] & r[B_CFL]) | (r[B_GEN] & periph);
    return r[B_MEN] & any_src;
  endfunction
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/intr_edge_det.sv
module intr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_sel,
  output logic evt
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign evt = rise_sel ? (lvl & ~prev) : (~lvl & prev);
endmodule

// File: rtl/intr_port_cmp.sv
module intr_port_cmp #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         rd,
  output logic         mis
);
  logic [W-1:0] snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  snap <= '0;
    else if (rd) snap <= pins;
  end

  assign mis = |(pins ^ snap);
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_ctrl_pkg::*;
#(
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ovf_i,
  input  logic              ext_pin_i,
  input  logic [PORT_W-1:0] port_hi_i,
  input  logic              port_rd_i,
  input  logic              edge_rise_sel_i,
  input  logic              periph_irq_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic              ext_s;
  logic [PORT_W-1:0] port_s;
  logic              ext_evt;
  logic              port_mis;
  logic [REG_W-1:0]  ctl_q;
  logic [REG_W-1:0]  ctl_d;

  intr_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin_i), .q(ext_s)
  );

  intr_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_port_sync (
    .clk(clk), .rst_n(rst_n), .d(port_hi_i), .q(port_s)
  );

  intr_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ext_s), .rise_sel(edge_rise_sel_i), .evt(ext_evt)
  );

  intr_port_cmp #(.W(PORT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .pins(port_s), .rd(port_rd_i), .mis(port_mis)
  );

  always_comb begin
    ctl_d = reg_wr_i ? reg_wdata_i : ctl_q;
    ctl_d[B_TFL] = flag_next(ctl_q[B_TFL], reg_wr_i, reg_wdata_i[B_TFL], tmr_ovf_i);
    ctl_d[B_XFL] = flag_next(ctl_q[B_XFL], reg_wr_i, reg_wdata_i[B_XFL], ext_evt);
    ctl_d[B_CFL] = flag_next(ctl_q[B_CFL], reg_wr_i, reg_wdata_i[B_CFL], port_mis);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign reg_rdata_o = ctl_q;
  assign irq_o       = irq_eval(ctl_q, periph_irq_i);
endmodule

// File: rtl/intr_ctrl_chk.sv
module intr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tmr_ovf_i,
  input logic       periph_irq_i,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       irq_o,
  input logic       ext_evt,
  input logic       port_mis
);
  AST_IRQ_NEEDS_MEN: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata_o[7] |-> !irq_o); // R9
  AST_TMR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_i |=> reg_rdata_o[2]); // R3
  AST_EXT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> reg_rdata_o[1]); // R4
  AST_MISMATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    port_mis |=> reg_rdata_o[0]); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[2] && !reg_wr_i) |=> reg_rdata_o[2]); // R5
  AST_PERIPH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_irq_i && reg_rdata_o[7] && reg_rdata_o[6]) |-> irq_o); // R10
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !tmr_ovf_i && !ext_evt && !port_mis) |=> reg_rdata_o == $past(reg_wdata_i)); // R2
endmodule

bind intr_ctrl intr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_ovf_i(tmr_ovf_i), .periph_irq_i(periph_irq_i),
  .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .irq_o(irq_o), .ext_evt(ext_evt), .port_mis(port_mis)
);

// File: tb/intr_ctrl_bench.sv
`timescale 1ns/1ps
module intr_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_ovf_i = 1'b0;
  logic       ext_pin_i = 1'b0;
  logic [3:0] port_hi_i = 4'h0;
  logic       port_rd_i = 1'b0;
  logic       edge_rise_sel_i = 1'b1;
  logic       periph_irq_i = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  intr_ctrl u_intr_ctrl (
    .clk(clk), .rst_n(rst_n), .tmr_ovf_i(tmr_ovf_i), .ext_pin_i(ext_pin_i),
    .port_hi_i(port_hi_i), .port_rd_i(port_rd_i), .edge_rise_sel_i(edge_rise_sel_i),
    .periph_irq_i(periph_irq_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  function automatic logic model_irq(logic [7:0] r, logic p);
    logic [3:0] src;
    src = {r[6] & p, r[5:3] & r[2:0]};
    if (r[7] == 1'b0) return 1'b0;
    return src != 4'b0000;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    reg_wr_i = 1'b1; reg_wdata_i = v;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_r;
    void'($urandom(32'd1234));
    wait_n(3);
    // R1: reset state
    check("R1 reg", reg_rdata_o, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    rst_n = 1'b1;
    wait_n(2);
    check("R1 reg after release", reg_rdata_o, 8'h00);

    // R2: readback of enable bits
    wr(8'hA8);
    check("R2 readback", reg_rdata_o, 8'hA8);

    // R3: timer pulse with all enables off
    wr(8'h00);
    tmr_ovf_i = 1'b1; @(negedge clk); tmr_ovf_i = 1'b0;
    check("R3 timer flag", reg_rdata_o, 8'h04);
    wait_n(3);
    check("R5 timer flag holds", reg_rdata_o, 8'h04);
    // R9: enabled timer flag but master off, then on
    wr(8'h24);
    check("R9 no irq without master", {7'b0, irq_o}, 8'h00);
    wr(8'hA4);
    check("R9 irq with master", {7'b0, irq_o}, 8'h01);
    wr(8'hA0);
    check("R5 cleared by write 0", reg_rdata_o, 8'hA0);

    // R8: set and clear collide
    tmr_ovf_i = 1'b1; reg_wr_i = 1'b1; reg_wdata_i = 8'h00;
    @(negedge clk);
    tmr_ovf_i = 1'b0; reg_wr_i = 1'b0;
    check("R8 set wins", reg_rdata_o, 8'h04);
    wr(8'h00);

    // R4: rising select
    edge_rise_sel_i = 1'b1;
    ext_pin_i = 1'b1; wait_n(4);
    check("R4 rising sets", reg_rdata_o, 8'h02);
    wr(8'h00);
    ext_pin_i = 1'b0; wait_n(4);
    check("R4 falling ignored when rising", reg_rdata_o, 8'h00);
    // R4: falling select
    edge_rise_sel_i = 1'b0;
    ext_pin_i = 1'b1; wait_n(4);
    check("R4 rising ignored when falling", reg_rdata_o, 8'h00);
    ext_pin_i = 1'b0; wait_n(4);
    check("R4 falling sets", reg_rdata_o, 8'h02);
    wr(8'h00);
    edge_rise_sel_i = 1'b1;

    // R6: mismatch persists
    port_hi_i = 4'b0101; wait_n(4);
    check("R6 mismatch sets", reg_rdata_o, 8'h01);
    wr(8'h00); wait_n(1);
    check("R6 clear ineffective", reg_rdata_o, 8'h01);
    // R7: port read then clear
    port_rd_i = 1'b1; @(negedge clk); port_rd_i = 1'b0;
    wait_n(1);
    wr(8'h00); wait_n(2);
    check("R7 clear after read", reg_rdata_o, 8'h00);

    // R10: peripheral gating
    periph_irq_i = 1'b1;
    wr(8'h80); check("R10 group enable off", {7'b0, irq_o}, 8'h00);
    wr(8'h40); check("R10 master off", {7'b0, irq_o}, 8'h00);
    wr(8'hC0); check("R10 both on", {7'b0, irq_o}, 8'h01);
    periph_irq_i = 1'b0; wr(8'h00);

    // Random traffic: R2 R3 R5 R8 R9 against the bench model
    exp_r = reg_rdata_o;
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] nx;
      reg_wr_i     = ($urandom % 4) == 0;
      reg_wdata_i  = 8'($urandom);
      tmr_ovf_i    = ($urandom % 5) == 0;
      periph_irq_i = ($urandom % 2) == 0;
      nx = reg_wr_i ? reg_wdata_i : exp_r;
      if (tmr_ovf_i) nx[2] = 1'b1;
      @(negedge clk);
      exp_r = nx;
      check("R2/R3/R5/R8 random reg", reg_rdata_o, exp_r);
      check("R9 random irq", {7'b0, irq_o}, {7'b0, model_irq(exp_r, periph_irq_i)});
    end
    reg_wr_i = 1'b0; tmr_ovf_i = 1'b0; periph_irq_i = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule